// File: doc/BRIEF.md
# Buck Regulator Start-up and Protection Sequencer

This block is the digital sequencing core of a single-phase synchronous buck controller. It sees the analog side only as already-digitized comparator flags and a one-cycle pulse per switching period. From these it decides when the converter may start and produces the digital reference code that the error amplifier tracks. It also gates the high-side and low-side drivers, drives power-good and turns on an output bleed path.

A start needs both supply rails good and the enable input high. The block then waits a fixed number of switching periods and ramps the reference from zero to full scale under closed-loop regulation. Power-good is released a few periods later. Overvoltage is watched throughout. Undervoltage is only watched once the ramp is far enough along. Overcurrent has two levels: the lower one allows a bounded number of restarts and the upper one latches at once. Clearing enable or applying reset rearms everything.

Top module: `buck_seq_ctrl`

## Requirements
- R1: The block leaves idle only while both `supply_ok` and `enable` are high. It then holds both gate enables low for START_DLY switching ticks, and `hs_en` rises right after the last of those ticks.
- R2: During the ramp `ref_code` starts at 0 and rises by exactly one per switching tick until it reaches 2^REF_W-1. The ramp ends on the 2^REF_W-th tick after it began, so with REF_W=10 the code reaches 1023 after 1023 ticks.
- R3: `pgood` rises PG_DLY ticks after the ramp ends, which is 2^REF_W+PG_DLY ticks after `hs_en` rose. It then stays high with `ref_code` at full scale while no fault is flagged, and it is low in every other state.
- R4: `ov_flag` has the highest priority in every starting, running, waiting or retry state. It latches `hs_en`=0, `ls_en`=1 and `pgood`=0, and this holds after the flag clears until `enable` goes low or reset.
- R5: `uv_flag` is ignored during the ramp while `ref_code` is below the arm code (4/5 of 2^REF_W, which is 819 for REF_W=10). At or above the arm code it turns both gates off and returns `ref_code` to 0. The block then waits UV_DLY ticks and runs the full start again, start delay included.
- R6: `uv_flag` while regulating at full reference latches the block off: both gates are off, `pgood` is low and discharge is off.
- R7: `oc1_flag` during ramp or regulation turns both gates off and sets `dis_en` until `below_dis` is high, after which a new start (delay and ramp) begins. Up to MAX_RETRY (4) such restarts are allowed, and the next `oc1_flag` latches the block off with discharge off.
- R8: `oc2_flag` during ramp or regulation latches the block off at once, whatever the restart count.
- R9: Taking `enable` low releases any latched state and clears the restart count.
- R10: Taking `enable` (or `supply_ok`) low while starting or running turns both gates off and sets `dis_en` until `below_dis` is high. The block then returns to idle with all outputs low.
- R11: In each new start `ls_en` stays low until the first `pwm_pulse` during the ramp or regulation, except in the overvoltage latch.
- R12: Synchronous reset gives `ref_code`=0 and `hs_en`, `ls_en`, `pgood`, `dis_en` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| supply_ok | input | 1 | Both supply rails above their lockout thresholds |
| enable | input | 1 | Converter enable |
| ov_flag | input | 1 | Output above overvoltage limit |
| uv_flag | input | 1 | Output below undervoltage limit |
| oc1_flag | input | 1 | Inductor current above the lower limit |
| oc2_flag | input | 1 | Inductor current above the upper limit |
| below_dis | input | 1 | Output below half the reference |
| pwm_pulse | input | 1 | A PWM on-pulse has been issued |
| ref_code | output | REF_W | Digital reference for the error amplifier |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |
| pgood | output | 1 | Power-good |
| dis_en | output | 1 | Output discharge enable |

## Verification
The bench keeps REF_W at 10, so the real 1024-tick ramp and the 819 arm code are exercised unscaled. It shortens START_DLY to 4 and UV_DLY to 6 and issues a tick every fourth clock. This keeps a full start inside a few thousand cycles, so a bench can run several complete ramps, five overcurrent events and an undervoltage restart. Exact tick counts are checked for the start delay, the restart delay, the ramp length and the power-good delay.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic [3:0] {
    ST_OFF,
    ST_DELAY,
    ST_RAMP,
    ST_RUN,
    ST_UVWAIT,
    ST_OCSTOP,
    ST_DISCHG,
    ST_LATCH_OV,
    ST_LATCH_OFF
  } seq_state_t;
endpackage

// File: rtl/bseq_timer.sv
module bseq_timer #(
  parameter int TM_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [TM_W-1:0] load_val,
  input  logic            tick,
  output logic            done
);
  logic [TM_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  assert_timer_monotone_R1: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/bseq_ramp.sv
module bseq_ramp #(
  parameter int REF_W = 10,
  parameter int ARM   = 819
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [REF_W-1:0] code,
  output logic             full,
  output logic             armed
);
  localparam logic [REF_W-1:0] MAXC = {REF_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)         code <= '0;
    else if (step && !full) code <= code + 1'b1;
  end

  assign full  = (code == MAXC);
  assign armed = (int'(code) >= ARM);

  assert_ref_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && code != $past(code)) |-> (code == $past(code) + 1'b1));
endmodule

// File: rtl/bseq_retry.sv
module bseq_retry #(
  parameter int MAX_RETRY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic spent
);
  localparam int CW = $clog2(MAX_RETRY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)         cnt <= '0;
    else if (inc && !spent) cnt <= cnt + 1'b1;
  end

  assign spent = (int'(cnt) == MAX_RETRY);

  assert_retry_bound_R7: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= MAX_RETRY);
endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
  import buck_seq_pkg::*;
#(
  parameter int REF_W     = 10,
  parameter int TM_W      = 16,
  parameter int START_DLY = 64,
  parameter int UV_DLY    = 64,
  parameter int PG_DLY    = 3,
  parameter int MAX_RETRY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_tick,
  input  logic             supply_ok,
  input  logic             enable,
  input  logic             ov_flag,
  input  logic             uv_flag,
  input  logic             oc1_flag,
  input  logic             oc2_flag,
  input  logic             below_dis,
  input  logic             pwm_pulse,
  output logic [REF_W-1:0] ref_code,
  output logic             hs_en,
  output logic             ls_en,
  output logic             pgood,
  output logic             dis_en
);
  localparam int ARM_CODE = ((1 << REF_W) * 4) / 5;
  localparam logic [TM_W-1:0] T_START = TM_W'(START_DLY);
  localparam logic [TM_W-1:0] T_UV    = TM_W'(UV_DLY);
  localparam logic [TM_W-1:0] T_PG    = TM_W'(PG_DLY);

  seq_state_t state, state_n;
  logic tm_load, tm_done;
  logic [TM_W-1:0] tm_val;
  logic rp_clr, rp_step, rp_full, rp_armed;
  logic rt_inc, rt_spent;
  logic seen_pwm, seen_n, pg_n;
  logic go, regulating;

  bseq_timer #(.TM_W(TM_W)) u_timer (
    .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val),
    .tick(sw_tick), .done(tm_done));

  bseq_ramp #(.REF_W(REF_W), .ARM(ARM_CODE)) u_ramp (
    .clk(clk), .rst(rst), .clr(rp_clr), .step(rp_step),
    .code(ref_code), .full(rp_full), .armed(rp_armed));

  bseq_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst(rst), .clr(!enable), .inc(rt_inc), .spent(rt_spent));

  assign go         = enable && supply_ok;
  assign regulating = (state == ST_RAMP) || (state == ST_RUN);

  always_comb begin
    state_n = state;
    tm_load = 1'b0;
    tm_val  = '0;
    rp_step = 1'b0;
    rt_inc  = 1'b0;
    case (state)
      ST_OFF: if (go) begin
        state_n = ST_DELAY; tm_load = 1'b1; tm_val = T_START;
      end
      ST_LATCH_OV, ST_LATCH_OFF: if (!enable) state_n = ST_OFF;
      ST_DISCHG: if (below_dis) state_n = ST_OFF;
      default: begin
        if (ov_flag)                    state_n = ST_LATCH_OV;
        else if (!go)                   state_n = ST_DISCHG;
        else if (oc2_flag && regulating) state_n = ST_LATCH_OFF;
        else if (oc1_flag && regulating) begin
          if (rt_spent) state_n = ST_LATCH_OFF;
          else begin rt_inc = 1'b1; state_n = ST_OCSTOP; end
        end else begin
          case (state)
            ST_DELAY: if (tm_done) state_n = ST_RAMP;
            ST_RAMP: begin
              if (uv_flag && rp_armed) begin
                state_n = ST_UVWAIT; tm_load = 1'b1; tm_val = T_UV;
              end else if (sw_tick) begin
                if (rp_full) begin
                  state_n = ST_RUN; tm_load = 1'b1; tm_val = T_PG;
                end else rp_step = 1'b1;
              end
            end
            ST_RUN: if (uv_flag) state_n = ST_LATCH_OFF;
            ST_UVWAIT: if (tm_done) begin
              state_n = ST_DELAY; tm_load = 1'b1; tm_val = T_START;
            end
            ST_OCSTOP: if (below_dis) begin
              state_n = ST_DELAY; tm_load = 1'b1; tm_val = T_START;
            end
            default: state_n = state;
          endcase
        end
      end
    endcase
  end

  assign rp_clr = (state_n != ST_RAMP) && (state_n != ST_RUN);
  assign seen_n = ((state_n == ST_RAMP) || (state_n == ST_RUN)) && (seen_pwm || pwm_pulse);
  assign pg_n   = (state == ST_RUN) && (state_n == ST_RUN) && tm_done && !tm_load
                  && !ov_flag && !uv_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OFF;
      seen_pwm <= 1'b0;
      hs_en    <= 1'b0;
      ls_en    <= 1'b0;
      pgood    <= 1'b0;
      dis_en   <= 1'b0;
    end else begin
      state    <= state_n;
      seen_pwm <= seen_n;
      hs_en    <= (state_n == ST_RAMP) || (state_n == ST_RUN);
      ls_en    <= (state_n == ST_LATCH_OV) || seen_n;
      pgood    <= pg_n;
      dis_en   <= (state_n == ST_DISCHG) || (state_n == ST_OCSTOP);
    end
  end

  assert_discharge_gates_off_R10: assert property (@(posedge clk) disable iff (rst)
    dis_en |-> (!hs_en && !ls_en));

  assert_pgood_full_ref_R3: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (ref_code == {REF_W{1'b1}}));

  assert_ov_latch_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH_OV && enable) |=> (state == ST_LATCH_OV && ls_en && !hs_en));

  assert_uv_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RAMP && !rp_armed && go && !ov_flag && !oc1_flag && !oc2_flag)
      |=> hs_en);
endmodule

// File: tb/buck_seq_ctrl_tb.sv
module buck_seq_ctrl_tb;
  localparam int REF_W = 10, START_DLY = 4, UV_DLY = 6, PG_DLY = 3, MAX_RETRY = 4;
  localparam int FULL = (1 << REF_W) - 1;
  localparam int ARMC = 819;

  logic clk = 1'b0, rst = 1'b1;
  logic supply_ok = 0, enable = 0, ov = 0, uv = 0, oc1 = 0, oc2 = 0, below = 0, pwm = 0;
  logic [1:0] div = 2'd0;
  logic sw_tick;
  logic [REF_W-1:0] ref_code;
  logic hs_en, ls_en, pgood, dis_en;
  int tick_cnt = 0;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  typedef struct { string req; int val; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign sw_tick = (div == 2'd0);
  always @(posedge clk) if (sw_tick) tick_cnt <= tick_cnt + 1;

  buck_seq_ctrl #(.REF_W(REF_W), .TM_W(8), .START_DLY(START_DLY), .UV_DLY(UV_DLY),
                  .PG_DLY(PG_DLY), .MAX_RETRY(MAX_RETRY)) u_dut (
    .clk(clk), .rst(rst), .sw_tick(sw_tick), .supply_ok(supply_ok), .enable(enable),
    .ov_flag(ov), .uv_flag(uv), .oc1_flag(oc1), .oc2_flag(oc2), .below_dis(below),
    .pwm_pulse(pwm), .ref_code(ref_code), .hs_en(hs_en), .ls_en(ls_en),
    .pgood(pgood), .dis_en(dis_en));

  // driver side: push the expected item
  task automatic expect_item(string req, int val);
    exp_t e;
    e.req = req; e.val = val;
    exp_q.push_back(e);
  endtask

  // monitor side: pop and compare against what the design produced
  task automatic observe(int act);
    exp_t e;
    e = exp_q.pop_front();
    checks++;
    if (act != e.val) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", e.req, act, e.val);
    end
  endtask

  task automatic chk(string req, int act, int val);
    expect_item(req, val);
    observe(act);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // land on a negedge whose following posedge carries no tick
  task automatic align();
    do @(negedge clk); while (!sw_tick);
    @(negedge clk);
  endtask

  task automatic wait_hs(output int ticks);
    int t0 = tick_cnt;
    for (int g = 0; g < 400 && !hs_en; g++) step(1);
    ticks = tick_cnt - t0;
  endtask

  task automatic wait_pgood();
    for (int g = 0; g < 6000 && !pgood; g++) step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    int t0;
    step(4);
    rst = 1'b0;
    step(1);
    chk("R12 ref_code", int'(ref_code), 0);
    chk("R12 hs_en", int'(hs_en), 0);
    chk("R12 ls_en", int'(ls_en), 0);
    chk("R12 pgood/dis_en", int'(pgood) + int'(dis_en), 0);

    // R1: enable without supply stays idle
    enable = 1'b1;
    step(40);
    chk("R1 idle without supply", int'(hs_en), 0);
    enable = 1'b0;
    step(2);

    align();
    supply_ok = 1'b1; enable = 1'b1;
    wait_hs(t);
    chk("R1 start delay ticks", t, START_DLY);
    chk("R2 ramp starts at 0", int'(ref_code), 0);
    chk("R11 low side off before pwm", int'(ls_en), 0);

    // R5: uv below arm code ignored
    step(40);
    uv = 1'b1; step(8); uv = 1'b0;
    chk("R5 uv masked early", int'(hs_en), 1);
    pwm = 1'b1; step(1); pwm = 1'b0; step(1);
    chk("R11 low side after pwm", int'(ls_en), 1);

    for (int g = 0; g < 6000 && int'(ref_code) < ARMC; g++) step(1);
    align();
    uv = 1'b1; t0 = tick_cnt; step(1); uv = 1'b0;
    chk("R5 uv armed gates off", int'(hs_en) + int'(ls_en), 0);
    chk("R5 uv armed ref cleared", int'(ref_code), 0);
    for (int g = 0; g < 400 && !hs_en; g++) step(1);
    chk("R5 restart ticks", tick_cnt - t0, UV_DLY + START_DLY);
    chk("R11 low side off after restart", int'(ls_en), 0);

    // R2 / R3 full ramp timing
    t0 = tick_cnt;
    for (int g = 0; g < 6000 && int'(ref_code) != FULL; g++) step(1);
    chk("R2 ticks to full scale", tick_cnt - t0, FULL);
    chk("R3 pgood low at full scale", int'(pgood), 0);
    wait_pgood();
    chk("R3 ticks to pgood", tick_cnt - t0, FULL + 1 + PG_DLY);
    step(20);
    chk("R3 pgood held", int'(pgood), 1);
    chk("R3 ref held full", int'(ref_code), FULL);

    // R4 overvoltage latch
    ov = 1'b1; step(1); ov = 1'b0;
    chk("R4 ov hs off", int'(hs_en), 0);
    chk("R4 ov ls on", int'(ls_en), 1);
    chk("R4 ov pgood low", int'(pgood), 0);
    step(40);
    chk("R4 ov latched", int'(ls_en) * 2 + int'(hs_en), 2);
    enable = 1'b0; step(2);
    chk("R9 disable releases ov latch", int'(ls_en), 0);

    // R6 undervoltage while regulating
    align(); enable = 1'b1;
    wait_hs(t);
    wait_pgood();
    uv = 1'b1; step(1); uv = 1'b0;
    chk("R6 uv run pgood low", int'(pgood), 0);
    step(40);
    chk("R6 uv run latched", int'(hs_en) + int'(ls_en) + int'(dis_en), 0);
    enable = 1'b0; step(2);

    // R7 overcurrent level 1 retries
    align(); enable = 1'b1;
    wait_hs(t);
    for (int k = 0; k < MAX_RETRY; k++) begin
      step(8);
      oc1 = 1'b1; step(1); oc1 = 1'b0;
      chk("R7 oc1 gates off", int'(hs_en), 0);
      chk("R7 oc1 discharge on", int'(dis_en), 1);
      step(10);
      chk("R7 discharge held until threshold", int'(dis_en), 1);
      align(); below = 1'b1;
      wait_hs(t);
      below = 1'b0;
      chk("R7 re-entry delay", t, START_DLY);
    end
    step(8);
    oc1 = 1'b1; step(1); oc1 = 1'b0;
    chk("R7 fifth oc1 latches", int'(hs_en) + int'(dis_en), 0);
    step(60);
    chk("R7 latch holds", int'(hs_en), 0);

    // R9 disable clears retry count
    enable = 1'b0; step(2);
    align(); enable = 1'b1;
    wait_hs(t);
    step(8);
    oc1 = 1'b1; step(1); oc1 = 1'b0;
    chk("R9 retry count cleared", int'(dis_en), 1);
    align(); below = 1'b1;
    wait_hs(t);
    below = 1'b0;

    // R8 overcurrent level 2
    step(8);
    oc2 = 1'b1; step(1); oc2 = 1'b0;
    chk("R8 oc2 latch", int'(hs_en) + int'(dis_en), 0);
    step(40);
    chk("R8 oc2 latch holds", int'(hs_en), 0);

    // R10 normal disable with discharge
    enable = 1'b0; step(2);
    align(); enable = 1'b1;
    wait_hs(t);
    step(8);
    enable = 1'b0; step(1);
    chk("R10 disable gates off", int'(hs_en) + int'(ls_en), 0);
    chk("R10 disable discharge", int'(dis_en), 1);
    step(10);
    chk("R10 discharge held", int'(dis_en), 1);
    below = 1'b1; step(2);
    chk("R10 discharge ends", int'(dis_en), 0);
    below = 1'b0;

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule